// File: doc/BRIEF.md
# Configuration-Hold Control Register Bank

This block holds the control registers of a hub-style device. A management host programs these registers over a serial side-band bus before the device may attach to its upstream port. The block sees the host through a byte-wide register port: an address, write data, a write strobe and a combinational read-data bus. It also takes an active-low global reset and a mode-select pin, and it drives one output that permits the upstream connection.

The mode-select pin is captured while the global reset is held. A low value selects side-band configuration mode. In that mode a "configuration active" latch starts at 1 and holds the upstream connect off. The host programs the port-configuration registers and then writes 1 to the latch bit to release the connect. No register write can set the latch again. Only the global reset can set it, or a self-clearing soft-reset bit, which also reloads every register to its power-on default.

A high mode-select value bypasses configuration. The latch comes out of reset at 0, the connect is permitted at once, and register writes are ignored.

Top module: `cfghold_regbank`

## Requirements
- R1: While the global reset is held with the mode-select pin low, the registers take their defaults. The control register at address 0xF8 then reads 0x01 (configuration-active, bit 0, set) and the connect output is low.
- R2: While configuration-active is 1, the upstream-connect output stays 0, whatever port registers are written.
- R3: In configuration mode, a write to 0xF8 with bit 0 set clears configuration-active. The connect output is 1 from the next cycle and 0xF8 reads 0x00.
- R4: A write to 0xF8 with bit 0 clear leaves configuration-active unchanged. This holds whether the bit is 1 or already 0. No write ever sets it to 1.
- R5: There are NUM_PORT_REGS read/write port-configuration registers at consecutive addresses from 0xF0. Register i defaults to 0xA1 + i*0x11, so the defaults are 0xA1, 0xB2, 0xC3 and so on.
- R6: In configuration mode, writing 1 to bit 3 of 0xF8 starts a soft reset. One cycle later every port register reloads its default and configuration-active returns to 1. Bit 3 always reads 0.
- R7: When the mode-select pin was captured high, a soft-reset write has no effect, and the connect output stays 1.
- R8: When the mode-select pin was captured high, configuration-active is 0, the connect output is 1 from reset, 0xF8 reads 0x00, and all register writes are ignored.
- R9: Reads of any address other than 0xF0..0xF0+NUM_PORT_REGS-1 and 0xF8 return 0x00.
- R10: The mode-select pin is captured only while the global reset is low. Changing it after reset alters neither the write behaviour nor the connect output.
- R11: Asserting the global reset in mid-operation restores all register defaults and sets configuration-active to 1 again when the mode-select pin is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Global reset, active low, synchronous |
| mode_pin | input | 1 | Mode select, captured during reset: 0 = side-band configuration, 1 = bypass |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register (combinational) |
| up_connect_en | output | 1 | Permits the upstream connection when 1 |

## Verification
The bench builds the block with five port registers instead of the default four. The defaults therefore run up to 0xE5 at 0xF4, and the window of valid addresses ends directly beside the unmapped 0xF5..0xF7 gap below the control register. The expected defaults come from the stated formula. The soft reset is sampled in the cycle between the write and the reload, so the one-cycle delay is checked exactly. Both mode-pin values are run, and the pin is also toggled after reset.

// File: rtl/cfghold_pkg.sv
// Package: shared widths and the default-value rule for the configuration-hold register bank.
// Assumes byte-wide data and addresses throughout.
package cfghold_pkg;
    localparam int unsigned DW = 8;
    localparam int unsigned AW = 8;

    typedef logic [DW-1:0] cfg_byte_t;
    typedef logic [AW-1:0] cfg_addr_t;

    // Default of port register idx: base plus idx steps, wrapped to a byte.
    function automatic cfg_byte_t port_default(input int idx, input cfg_byte_t base, input cfg_byte_t step);
        return cfg_byte_t'(int'(base) + idx * int'(step));
    endfunction
endpackage

// File: rtl/cfghold_mode_latch.sv
// Module: captures the mode-select pin while the global reset is low and holds it afterwards.
// Assumes rst_n is synchronous to clk; the last value seen during reset is kept.
module cfghold_mode_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_pin,
    output logic mode_q
);
    // Track the pin during reset, freeze once reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= mode_pin;
        end
    end
endmodule

// File: rtl/cfghold_ctl.sv
// Module: control register holding the configuration-active latch and the soft-reset pulse.
// Assumes the clear and soft-reset requests are already qualified by the write decode.
// A soft reset request sets srst_q for one cycle; that cycle reloads defaults and sets the latch.
module cfghold_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_pin,
    input  logic mode_q,
    input  logic clr_req,
    input  logic srst_req,
    output logic cfg_active,
    output logic srst_q
);
    // Latch and soft-reset pulse; reload has priority over any write in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_active <= !mode_pin;
            srst_q     <= 1'b0;
        end else if (srst_q) begin
            cfg_active <= 1'b1;
            srst_q     <= 1'b0;
        end else if (!mode_q) begin
            if (clr_req) begin
                cfg_active <= 1'b0;
            end
            if (srst_req) begin
                srst_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfghold_portfile.sv
// Module: bank of read/write port-configuration registers at consecutive addresses.
// Assumes wr_ok already folds in the mode gating; reload restores each register's default.
module cfghold_portfile
    import cfghold_pkg::*;
#(
    parameter int        NUM_REGS  = 4,
    parameter cfg_addr_t BASE_ADDR = 8'hF0,
    parameter cfg_byte_t DEF_BASE  = 8'hA1,
    parameter cfg_byte_t DEF_STEP  = 8'h11
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reload,
    input  logic                     wr_ok,
    input  cfg_addr_t                addr,
    input  cfg_byte_t                wdata,
    output cfg_byte_t [NUM_REGS-1:0] regs
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam cfg_addr_t MY_ADDR = cfg_addr_t'(int'(BASE_ADDR) + g);
        localparam cfg_byte_t MY_DEF  = port_default(g, DEF_BASE, DEF_STEP);

        // One register: default on global or soft reset, else load on an addressed write.
        always_ff @(posedge clk) begin
            if (!rst_n || reload) begin
                regs[g] <= MY_DEF;
            end else if (wr_ok && addr == MY_ADDR) begin
                regs[g] <= wdata;
            end
        end
    end
endmodule

// File: rtl/cfghold_regbank.sv
// Module: top of the configuration-hold register bank.
// Decodes the byte-wide register port, gates writes by the captured mode, muxes reads and
// holds the upstream connect off while configuration-active is set.
// Assumes a single-cycle write strobe and a combinational read of the current address.
module cfghold_regbank
    import cfghold_pkg::*;
#(
    parameter int        NUM_PORT_REGS = 4,
    parameter cfg_addr_t PORT_BASE     = 8'hF0,
    parameter cfg_addr_t CTL_ADDR      = 8'hF8,
    parameter cfg_byte_t DEF_BASE      = 8'hA1,
    parameter cfg_byte_t DEF_STEP      = 8'h11,
    parameter int        CFG_BIT       = 0,
    parameter int        SRST_BIT      = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_pin,
    input  logic       wr_en,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       up_connect_en
);
    logic      mode_q;
    logic      cfg_active;
    logic      srst_q;
    logic      wr_ctl;
    cfg_byte_t [NUM_PORT_REGS-1:0] port_regs;

    assign wr_ctl = wr_en && (addr == CTL_ADDR);

    cfghold_mode_latch u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_pin (mode_pin),
        .mode_q   (mode_q)
    );

    cfghold_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_pin   (mode_pin),
        .mode_q     (mode_q),
        .clr_req    (wr_ctl && wdata[CFG_BIT]),
        .srst_req   (wr_ctl && wdata[SRST_BIT]),
        .cfg_active (cfg_active),
        .srst_q     (srst_q)
    );

    cfghold_portfile #(
        .NUM_REGS  (NUM_PORT_REGS),
        .BASE_ADDR (PORT_BASE),
        .DEF_BASE  (DEF_BASE),
        .DEF_STEP  (DEF_STEP)
    ) u_ports (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (srst_q),
        .wr_ok  (wr_en && !mode_q),
        .addr   (addr),
        .wdata  (wdata),
        .regs   (port_regs)
    );

    // Read mux: control register shows only the latch; unmapped addresses read zero.
    always_comb begin
        rdata = '0;
        if (addr == CTL_ADDR) begin
            rdata[CFG_BIT] = cfg_active;
        end
        for (int i = 0; i < NUM_PORT_REGS; i++) begin
            if (addr == cfg_addr_t'(int'(PORT_BASE) + i)) begin
                rdata = port_regs[i];
            end
        end
    end

    assign up_connect_en = !cfg_active;
endmodule

// File: rtl/cfghold_chk.sv
// Module: assertion checker for cfghold_regbank, attached by bind below.
// Assumes it sees the top's ports plus the captured mode and the soft-reset pulse.
module cfghold_chk #(
    parameter int         NUM_PORT_REGS = 4,
    parameter logic [7:0] PORT_BASE     = 8'hF0,
    parameter logic [7:0] CTL_ADDR      = 8'hF8,
    parameter int         CFG_BIT       = 0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] addr,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       up_connect_en,
    input logic       mode_q,
    input logic       srst_q
);
    logic unmapped;
    assign unmapped = (int'(addr) < int'(PORT_BASE) || int'(addr) >= int'(PORT_BASE) + NUM_PORT_REGS)
                      && addr != CTL_ADDR;

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == CTL_ADDR && wdata[CFG_BIT] && !srst_q && !mode_q) |=> up_connect_en);

    p_no_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (up_connect_en && !srst_q) |=> up_connect_en);

    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |=> (!up_connect_en && !srst_q));

    p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q |-> up_connect_en);

    p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> rdata == 8'h00);

    p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(mode_q));
endmodule

bind cfghold_regbank cfghold_chk #(
    .NUM_PORT_REGS (NUM_PORT_REGS),
    .PORT_BASE     (PORT_BASE),
    .CTL_ADDR      (CTL_ADDR),
    .CFG_BIT       (CFG_BIT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .addr          (addr),
    .wdata         (wdata),
    .rdata         (rdata),
    .up_connect_en (up_connect_en),
    .mode_q        (mode_q),
    .srst_q        (srst_q)
);

// File: tb/sim_cfghold_regbank.sv
// Bench: scoreboard for cfghold_regbank. Driver tasks act on the falling edge and queue
// expected items; the monitor compares them 2 ns later, away from either clock edge.
module sim_cfghold_regbank;
    localparam int         NP   = 5;
    localparam logic [7:0] PB   = 8'hF0;
    localparam logic [7:0] CTL  = 8'hF8;
    localparam logic [7:0] DB   = 8'hA1;
    localparam logic [7:0] DS   = 8'h11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_pin = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       up_connect_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit         is_conn;
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;

    cfghold_regbank #(.NUM_PORT_REGS(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_pin(mode_pin), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .up_connect_en(up_connect_en)
    );

    function automatic logic [7:0] def_of(input int i);
        return 8'(int'(DB) + i * int'(DS));
    endfunction

    // Monitor: pop and compare every queued expectation 2 ns after the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sb.pop_front();
                act = it.is_conn ? {7'b0, up_connect_en} : rdata;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic do_reset(input logic m);
        @(negedge clk);
        rst_n = 1'b0; mode_pin = m; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Read check in the current cycle, without waiting for another edge.
    task automatic rd_now(input logic [7:0] a, input logic [7:0] e, input string tag);
        addr = a;
        sb.push_back('{1'b0, e, tag});
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        rd_now(a, e, tag);
    endtask

    task automatic conn_now(input logic e, input string tag);
        sb.push_back('{1'b1, {7'b0, e}, tag});
    endtask

    task automatic conn(input logic e, input string tag);
        @(negedge clk);
        conn_now(e, tag);
    endtask

    initial begin
        // Run 1: side-band configuration mode.
        do_reset(1'b0);
        conn(1'b0, "R1 connect held after reset");
        rd(CTL, 8'h01, "R1 control reads latch set");
        for (int i = 0; i < NP; i++) rd(8'(int'(PB) + i), def_of(i), "R1 R5 default");
        rd(8'hF5, 8'h00, "R9 gap above ports");
        rd(8'hF7, 8'h00, "R9 gap below control");
        rd(8'h00, 8'h00, "R9 low address");
        rd(8'hFF, 8'h00, "R9 high address");
        for (int i = 0; i < NP; i++) wr(8'(int'(PB) + i), 8'(8'h5A + i));
        for (int i = 0; i < NP; i++) rd(8'(int'(PB) + i), 8'(8'h5A + i), "R5 readback");
        conn(1'b0, "R2 connect held while configuring");
        wr(CTL, 8'h00);
        rd(CTL, 8'h01, "R4 zero write keeps latch");
        conn(1'b0, "R2 connect still held");
        wr(CTL, 8'h01);
        conn_now(1'b0 ^ 1'b1, "R3 connect next cycle");
        rd(CTL, 8'h00, "R3 latch cleared");
        wr(CTL, 8'h00);
        rd(CTL, 8'h00, "R4 zero write cannot set");
        wr(CTL, 8'hF6);
        rd(CTL, 8'h00, "R4 other bits cannot set");
        conn(1'b1, "R4 connect stays on");
        // Soft reset: pulse cycle shows old state, next cycle shows defaults.
        wr(CTL, 8'h08);
        rd_now(PB, 8'h5A, "R6 no reload before pulse cycle ends");
        conn_now(1'b1, "R6 latch not yet set");
        for (int i = 0; i < NP; i++) rd(8'(int'(PB) + i), def_of(i), "R6 reload default");
        rd(CTL, 8'h01, "R6 latch set, bit3 reads 0");
        conn(1'b0, "R6 connect held again");
        // Mode pin changed after reset must not matter.
        mode_pin = 1'b1;
        wr(8'hF1, 8'h77);
        rd(8'hF1, 8'h77, "R10 writes still accepted");
        conn(1'b0, "R10 connect still held");
        wr(CTL, 8'h01);
        conn(1'b1, "R10 clear still works");
        // Global reset in mid-run.
        do_reset(1'b0);
        rd(8'hF1, def_of(1), "R11 default restored");
        rd(CTL, 8'h01, "R11 latch set again");
        conn(1'b0, "R11 connect held");

        // Run 2: bypass mode.
        do_reset(1'b1);
        conn(1'b1, "R8 connect on from reset");
        rd(CTL, 8'h00, "R8 latch clear");
        wr(PB, 8'h55);
        rd(PB, def_of(0), "R8 write ignored");
        wr(CTL, 8'h08);
        @(negedge clk);
        conn(1'b1, "R7 soft reset ignored");
        rd(CTL, 8'h00, "R7 latch stays clear");
        mode_pin = 1'b0;
        wr(8'hF2, 8'h33);
        rd(8'hF2, def_of(2), "R10 still bypassed");
        conn(1'b1, "R10 connect unchanged");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule